// File: doc/BRIEF.md
# Write-Triggered Memory Error Injector

This block sits on the write path of a single memory-controller channel and deliberately corrupts selected writes so that the error-detection and error-handling logic downstream can be tested. A small register interface programs three things. The first is a 64-bit address-match word that gives a pattern for the decoded DRAM address (dimm, rank, bank, page, column), with one ignore flag per field. The second is an ECC flip mask. The third is a 5-bit control word that picks the error kind, the half-cacheline targeted and whether injection repeats.

Each write request passes through a one-cycle register stage. When a valid write matches every field that is not ignored, and its half-cacheline is selected, the injector flips the check bits set in the flip mask, raises an address-parity error flag on the outgoing request, or does both. It also pulses a status output. In one-shot mode only the first matching write is corrupted, and the unit stays quiet until software writes a configuration register again. Read requests always pass through untouched. The block does not compute or decode ECC.

Top module: `wr_err_injector`

## Requirements
- R1: After reset every configuration register reads zero, the fired flag is clear and no request is corrupted.
- R2: Register 0 (match word, 64 bits), register 1 (flip mask, ECC_W bits) and register 2 (control, 5 bits) read back what was written. Bits written above a register's width read back zero. Register 3 reads the fired flag in bit 0. A write takes effect on the next clock edge.
- R3: The match word places column at bits 13:0, page at 29:14 and bank at 33:30. Ignore flags sit at bit 41 (dimm), 40 (rank), 39 (bank), 38 (page) and 37 (column). A field matches when its ignore flag is set or when it equals the request field. An injection needs every field to match.
- R4: With the many-DIMM input high, dimm is bits 36:35 and rank is bit 34. With it low, dimm is bit 36 and rank is bits 35:34.
- R5: Only valid write requests can be corrupted. Read requests leave the check bits, parity flag and pulse untouched.
- R6: Control bits 2:1 select the halves of the cacheline: 01 the lower half (req_half=0), 10 the upper half (req_half=1), 11 both, 00 none.
- R7: With control bit 3 set, an injected write leaves with out_ecc equal to req_ecc XOR the flip mask.
- R8: With control bit 4 set, an injected write leaves with out_par_err high. This is independent of bit 3, and both may act on the same write.
- R9: While the flip mask is zero, no injection of either kind occurs.
- R10: With control bit 0 clear, only one write is corrupted. Further matches pass unchanged until any write to register 0, 1 or 2 re-arms the unit.
- R11: With control bit 0 set, every matching write is corrupted until the control word is cleared.
- R12: inj_pulse is high for exactly the output cycle of each injected write. The fired flag is set by the first injection and stays set until register 2 is written.
- R13: Each request appears at the outputs one clock after it is presented, with its address fields and write flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| many_dimms | input | 1 | High when the channel holds more than two DIMMs |
| cfg_wen | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Register select for write and read |
| cfg_wdata | input | 64 | Configuration write data |
| cfg_rdata | output | 64 | Read data of the selected register (combinational) |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dimm | input | 2 | DIMM index |
| req_rank | input | 2 | Rank index |
| req_bank | input | 4 | Bank index |
| req_page | input | 16 | Page (row) |
| req_col | input | 14 | Column |
| req_half | input | 1 | 0 = lower 32 bytes, 1 = upper 32 bytes |
| req_ecc | input | ECC_W | Check bits of the request |
| out_valid | output | 1 | Request present at output |
| out_write | output | 1 | Write flag of the output request |
| out_dimm | output | 2 | DIMM index passed through |
| out_rank | output | 2 | Rank passed through |
| out_bank | output | 4 | Bank passed through |
| out_page | output | 16 | Page passed through |
| out_col | output | 14 | Column passed through |
| out_half | output | 1 | Half-cacheline passed through |
| out_ecc | output | ECC_W | Check bits, possibly flipped |
| out_par_err | output | 1 | Injected address-parity error |
| inj_pulse | output | 1 | High for one cycle per injected write |

## Verification
A request driven before a rising edge shows at out_*, out_par_err and inj_pulse just after that edge. The bench therefore drives on the falling edge and samples one time unit after the following rising edge. A configuration write is captured at its edge, and the request in the next cycle sees it. So a scenario programs its registers, then sends requests and judges each one from the output sampled after its own edge. The fired flag and the other readback values come from a combinational read path, so they are sampled a time unit after cfg_addr is set on a falling edge.

// File: rtl/inj_pkg.sv
package inj_pkg;
  localparam int COL_W   = 14;
  localparam int PAGE_W  = 16;
  localparam int BANK_W  = 4;
  localparam int RANK_W  = 2;
  localparam int DIMM_W  = 2;
  localparam int CFG_W   = 64;
  localparam int CTRL_W  = 5;
  localparam int NFIELD  = 5;

  localparam int POS_COL       = 0;
  localparam int POS_PAGE      = 14;
  localparam int POS_BANK      = 30;
  localparam int POS_RANK      = 34;
  localparam int POS_DIMM_MANY = 35;
  localparam int POS_DIMM_FEW  = 36;
  localparam int POS_IGN       = 37;
  localparam int MATCH_USED_W  = POS_IGN + NFIELD;

  localparam int FLD_COL  = 0;
  localparam int FLD_PAGE = 1;
  localparam int FLD_BANK = 2;
  localparam int FLD_RANK = 3;
  localparam int FLD_DIMM = 4;

  localparam int CB_REPEAT = 0;
  localparam int CB_LO     = 1;
  localparam int CB_HI     = 2;
  localparam int CB_ECC    = 3;
  localparam int CB_PAR    = 4;

  typedef enum logic [1:0] {
    SEL_MATCH  = 2'd0,
    SEL_FLIP   = 2'd1,
    SEL_CTRL   = 2'd2,
    SEL_STATUS = 2'd3
  } cfg_sel_e;

  typedef struct packed {
    logic              write;
    logic [DIMM_W-1:0] dimm;
    logic [RANK_W-1:0] rank;
    logic [BANK_W-1:0] bank;
    logic [PAGE_W-1:0] page;
    logic [COL_W-1:0]  col;
    logic              half;
  } wreq_t;
endpackage

// File: rtl/inj_cfg_regs.sv
module inj_cfg_regs
  import inj_pkg::*;
#(
  parameter int ECC_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_wen,
  input  logic [1:0]              cfg_addr,
  input  logic [CFG_W-1:0]        cfg_wdata,
  output logic [CFG_W-1:0]        cfg_rdata,
  input  logic                    fire,
  output logic [MATCH_USED_W-1:0] match_used,
  output logic [ECC_W-1:0]        flip_mask,
  output logic [CTRL_W-1:0]       ctrl,
  output logic                    armed
);
  logic [CFG_W-1:0]  match_q, match_d;
  logic [ECC_W-1:0]  flip_q, flip_d;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic              armed_q, armed_d;
  logic              fired_q, fired_d;
  cfg_sel_e          sel;

  assign sel = cfg_sel_e'(cfg_addr);

  always_comb begin
    match_d = match_q;
    flip_d  = flip_q;
    ctrl_d  = ctrl_q;
    armed_d = armed_q;
    fired_d = fired_q;
    if (fire) begin
      fired_d = 1'b1;
      if (!ctrl_q[CB_REPEAT]) armed_d = 1'b0;
    end
    if (cfg_wen) begin
      case (sel)
        SEL_MATCH: begin
          match_d = cfg_wdata;
          armed_d = 1'b1;
        end
        SEL_FLIP: begin
          flip_d  = cfg_wdata[ECC_W-1:0];
          armed_d = 1'b1;
        end
        SEL_CTRL: begin
          ctrl_d  = cfg_wdata[CTRL_W-1:0];
          armed_d = 1'b1;
          fired_d = 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= '0;
      flip_q  <= '0;
      ctrl_q  <= '0;
      armed_q <= 1'b0;
      fired_q <= 1'b0;
    end else begin
      match_q <= match_d;
      flip_q  <= flip_d;
      ctrl_q  <= ctrl_d;
      armed_q <= armed_d;
      fired_q <= fired_d;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (sel)
      SEL_MATCH:  cfg_rdata = match_q;
      SEL_FLIP:   cfg_rdata[ECC_W-1:0] = flip_q;
      SEL_CTRL:   cfg_rdata[CTRL_W-1:0] = ctrl_q;
      SEL_STATUS: cfg_rdata[0] = fired_q;
      default:    cfg_rdata = '0;
    endcase
  end

  assign match_used = match_q[MATCH_USED_W-1:0];
  assign flip_mask  = flip_q;
  assign ctrl       = ctrl_q;
  assign armed      = armed_q;

  // R10: a one-shot injection disarms the unit unless a config write lands
  p_oneshot_disarm_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !ctrl_q[CB_REPEAT] && !cfg_wen) |=> !armed_q);

  // R12: the fired flag only clears through a control-word write
  p_fired_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (fired_q && !(cfg_wen && sel == SEL_CTRL)) |=> fired_q);
endmodule

// File: rtl/inj_addr_match.sv
module inj_addr_match
  import inj_pkg::*;
(
  input  logic [MATCH_USED_W-1:0] match_used,
  input  logic                    many_dimms,
  input  logic [DIMM_W-1:0]       dimm,
  input  logic [RANK_W-1:0]       rank,
  input  logic [BANK_W-1:0]       bank,
  input  logic [PAGE_W-1:0]       page,
  input  logic [COL_W-1:0]        col,
  output logic                    addr_hit
);
  localparam int FW = PAGE_W;

  logic [FW-1:0]     pat [NFIELD];
  logic [FW-1:0]     val [NFIELD];
  logic [NFIELD-1:0] ign;
  logic [NFIELD-1:0] hit;
  logic [DIMM_W-1:0] dimm_pat;
  logic [RANK_W-1:0] rank_pat;

  always_comb begin
    if (many_dimms) begin
      dimm_pat = match_used[POS_DIMM_MANY +: DIMM_W];
      rank_pat = {1'b0, match_used[POS_RANK]};
    end else begin
      dimm_pat = {1'b0, match_used[POS_DIMM_FEW]};
      rank_pat = match_used[POS_RANK +: RANK_W];
    end
  end

  always_comb begin
    pat[FLD_COL]  = FW'(match_used[POS_COL +: COL_W]);
    pat[FLD_PAGE] = FW'(match_used[POS_PAGE +: PAGE_W]);
    pat[FLD_BANK] = FW'(match_used[POS_BANK +: BANK_W]);
    pat[FLD_RANK] = FW'(rank_pat);
    pat[FLD_DIMM] = FW'(dimm_pat);
    val[FLD_COL]  = FW'(col);
    val[FLD_PAGE] = FW'(page);
    val[FLD_BANK] = FW'(bank);
    val[FLD_RANK] = FW'(rank);
    val[FLD_DIMM] = FW'(dimm);
    ign           = match_used[POS_IGN +: NFIELD];
  end

  for (genvar f = 0; f < NFIELD; f++) begin : g_field
    assign hit[f] = ign[f] | (pat[f] == val[f]);
  end

  assign addr_hit = &hit;
endmodule

// File: rtl/inj_trigger.sv
module inj_trigger
  import inj_pkg::*;
#(
  parameter int ECC_W = 32
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_half,
  input  logic              addr_hit,
  input  logic [ECC_W-1:0]  flip_mask,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic              armed,
  output logic              fire,
  output logic              flip_ecc,
  output logic              flag_par
);
  logic half_sel;
  logic kind_sel;
  logic allowed;

  always_comb begin
    half_sel = req_half ? ctrl[CB_HI] : ctrl[CB_LO];
    kind_sel = ctrl[CB_ECC] | ctrl[CB_PAR];
    allowed  = ctrl[CB_REPEAT] | armed;
    fire     = req_valid & req_write & addr_hit & half_sel & kind_sel
             & (|flip_mask) & allowed;
    flip_ecc = fire & ctrl[CB_ECC];
    flag_par = fire & ctrl[CB_PAR];
  end
endmodule

// File: rtl/inj_out_stage.sv
module inj_out_stage
  import inj_pkg::*;
#(
  parameter int ECC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  wreq_t            in_req,
  input  logic [ECC_W-1:0] in_ecc,
  input  logic [ECC_W-1:0] flip_mask,
  input  logic             fire,
  input  logic             flip_ecc,
  input  logic             flag_par,
  output logic             out_valid,
  output wreq_t            out_req,
  output logic [ECC_W-1:0] out_ecc,
  output logic             out_par_err,
  output logic             inj_pulse
);
  logic [ECC_W-1:0] ecc_d;
  wreq_t            req_q;
  logic [ECC_W-1:0] ecc_q;
  logic             valid_q, par_q, pulse_q;

  always_comb begin
    ecc_d = in_ecc ^ (flip_ecc ? flip_mask : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      par_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      valid_q <= in_valid;
      par_q   <= flag_par;
      pulse_q <= fire;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
      ecc_q <= '0;
    end else if (in_valid) begin
      req_q <= in_req;
      ecc_q <= ecc_d;
    end
  end

  assign out_valid   = valid_q;
  assign out_req     = req_q;
  assign out_ecc     = ecc_q;
  assign out_par_err = par_q;
  assign inj_pulse   = pulse_q;

  // R13: a request reaches the output exactly one cycle later
  p_latency_r13: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_no_phantom_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
endmodule

// File: rtl/wr_err_injector.sv
module wr_err_injector
  import inj_pkg::*;
#(
  parameter int ECC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             many_dimms,
  input  logic             cfg_wen,
  input  logic [1:0]       cfg_addr,
  input  logic [63:0]      cfg_wdata,
  output logic [63:0]      cfg_rdata,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [1:0]       req_dimm,
  input  logic [1:0]       req_rank,
  input  logic [3:0]       req_bank,
  input  logic [15:0]      req_page,
  input  logic [13:0]      req_col,
  input  logic             req_half,
  input  logic [ECC_W-1:0] req_ecc,
  output logic             out_valid,
  output logic             out_write,
  output logic [1:0]       out_dimm,
  output logic [1:0]       out_rank,
  output logic [3:0]       out_bank,
  output logic [15:0]      out_page,
  output logic [13:0]      out_col,
  output logic             out_half,
  output logic [ECC_W-1:0] out_ecc,
  output logic             out_par_err,
  output logic             inj_pulse
);
  logic [MATCH_USED_W-1:0] match_used;
  logic [ECC_W-1:0]        flip_mask;
  logic [CTRL_W-1:0]       ctrl;
  logic                    armed, addr_hit, fire, flip_ecc, flag_par;
  wreq_t                   in_req, o_req;

  assign in_req = '{write: req_write, dimm: req_dimm, rank: req_rank,
                    bank: req_bank, page: req_page, col: req_col,
                    half: req_half};

  inj_cfg_regs #(.ECC_W(ECC_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_wen(cfg_wen), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .fire(fire),
    .match_used(match_used), .flip_mask(flip_mask), .ctrl(ctrl),
    .armed(armed)
  );

  inj_addr_match u_match (
    .match_used(match_used), .many_dimms(many_dimms), .dimm(req_dimm),
    .rank(req_rank), .bank(req_bank), .page(req_page), .col(req_col),
    .addr_hit(addr_hit)
  );

  inj_trigger #(.ECC_W(ECC_W)) u_trig (
    .req_valid(req_valid), .req_write(req_write), .req_half(req_half),
    .addr_hit(addr_hit), .flip_mask(flip_mask), .ctrl(ctrl), .armed(armed),
    .fire(fire), .flip_ecc(flip_ecc), .flag_par(flag_par)
  );

  inj_out_stage #(.ECC_W(ECC_W)) u_out (
    .clk(clk), .rst_n(rst_n), .in_valid(req_valid), .in_req(in_req),
    .in_ecc(req_ecc), .flip_mask(flip_mask), .fire(fire),
    .flip_ecc(flip_ecc), .flag_par(flag_par), .out_valid(out_valid),
    .out_req(o_req), .out_ecc(out_ecc), .out_par_err(out_par_err),
    .inj_pulse(inj_pulse)
  );

  assign out_write = o_req.write;
  assign out_dimm  = o_req.dimm;
  assign out_rank  = o_req.rank;
  assign out_bank  = o_req.bank;
  assign out_page  = o_req.page;
  assign out_col   = o_req.col;
  assign out_half  = o_req.half;

  // R5: an injection is only ever reported on a valid write
  p_pulse_on_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    inj_pulse |-> (out_valid && out_write));

  // R8: a parity flag never appears without an injection
  p_par_with_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_par_err |-> inj_pulse);

  // R9: an injection implies a non-zero flip mask when it was decided
  p_mask_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    inj_pulse |-> ($past(flip_mask) != '0));

  // R7: unflipped check bits pass through when no injection happened
  p_ecc_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !fire) |=> (out_ecc == $past(req_ecc)));
endmodule

// File: tb/test_wr_err_injector.sv
module test_wr_err_injector;
  localparam int PER   = 10;
  localparam int ECC_W = 32;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             many_dimms;
  logic             cfg_wen;
  logic [1:0]       cfg_addr;
  logic [63:0]      cfg_wdata;
  logic [63:0]      cfg_rdata;
  logic             req_valid, req_write, req_half;
  logic [1:0]       req_dimm, req_rank;
  logic [3:0]       req_bank;
  logic [15:0]      req_page;
  logic [13:0]      req_col;
  logic [ECC_W-1:0] req_ecc;
  logic             out_valid, out_write, out_half, out_par_err, inj_pulse;
  logic [1:0]       out_dimm, out_rank;
  logic [3:0]       out_bank;
  logic [15:0]      out_page;
  logic [13:0]      out_col;
  logic [ECC_W-1:0] out_ecc;

  int n_chk = 0;
  int n_bad = 0;

  always #(PER/2) clk = ~clk;

  wr_err_injector #(.ECC_W(ECC_W)) i_wr_err_injector (
    .clk(clk), .rst_n(rst_n), .many_dimms(many_dimms), .cfg_wen(cfg_wen),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .req_valid(req_valid), .req_write(req_write), .req_dimm(req_dimm),
    .req_rank(req_rank), .req_bank(req_bank), .req_page(req_page),
    .req_col(req_col), .req_half(req_half), .req_ecc(req_ecc),
    .out_valid(out_valid), .out_write(out_write), .out_dimm(out_dimm),
    .out_rank(out_rank), .out_bank(out_bank), .out_page(out_page),
    .out_col(out_col), .out_half(out_half), .out_ecc(out_ecc),
    .out_par_err(out_par_err), .inj_pulse(inj_pulse)
  );

  task automatic check(input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // ignore vector order {dimm, rank, bank, page, col}
  function automatic logic [63:0] mk_match(input logic [4:0] ign,
      input logic [1:0] d, input logic [1:0] r, input logic [3:0] b,
      input logic [15:0] p, input logic [13:0] c, input logic many);
    logic [63:0] m;
    m = '0;
    m[13:0]  = c;
    m[29:14] = p;
    m[33:30] = b;
    if (many) begin
      m[36:35] = d;
      m[34]    = r[0];
    end else begin
      m[36]    = d[0];
      m[35:34] = r;
    end
    m[41:37] = ign;
    return m;
  endfunction

  task automatic cfg_wr(input logic [1:0] a, input logic [63:0] d);
    @(negedge clk);
    cfg_wen = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk);
    #1;
    @(negedge clk);
    cfg_wen = 1'b0;
  endtask

  task automatic cfg_rd(input string tag, input logic [1:0] a,
                        input logic [63:0] exp);
    @(negedge clk);
    cfg_addr = a;
    #1;
    check(tag, cfg_rdata, exp);
  endtask

  task automatic set_addr(input logic [1:0] d, input logic [1:0] r,
      input logic [3:0] b, input logic [15:0] p, input logic [13:0] c);
    req_dimm = d; req_rank = r; req_bank = b; req_page = p; req_col = c;
  endtask

  task automatic xfer(input string tag, input logic wr, input logic half,
      input logic [ECC_W-1:0] ecc, input logic [ECC_W-1:0] exp_ecc,
      input logic exp_par, input logic exp_pulse);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_half = half; req_ecc = ecc;
    @(posedge clk);
    #1;
    check({tag, " valid"}, 64'(out_valid), 64'd1);
    check({tag, " ecc"},   64'(out_ecc), 64'(exp_ecc));
    check({tag, " par"},   64'(out_par_err), 64'(exp_par));
    check({tag, " pulse"}, 64'(inj_pulse), 64'(exp_pulse));
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  localparam logic [ECC_W-1:0] E0 = 32'h1234_5678;
  localparam logic [ECC_W-1:0] M0 = 32'h0000_00A5;

  task automatic t_reset;
    cfg_rd("R1 match reset", 2'd0, 64'd0);
    cfg_rd("R1 flip reset", 2'd1, 64'd0);
    cfg_rd("R1 ctrl reset", 2'd2, 64'd0);
    cfg_rd("R1 status reset", 2'd3, 64'd0);
    check("R1 out_valid reset", 64'(out_valid), 64'd0);
    set_addr(2'd0, 2'd0, 4'd0, 16'd0, 14'd0);
    xfer("R1 write after reset", 1'b1, 1'b0, E0, E0, 1'b0, 1'b0);
  endtask

  task automatic t_regs;
    cfg_wr(2'd0, 64'hFEDC_BA98_7654_3210);
    cfg_wr(2'd1, 64'hFFFF_FFFF_0F0F_0F0F);
    cfg_wr(2'd2, 64'h0000_0000_0000_00FF);
    cfg_rd("R2 match readback", 2'd0, 64'hFEDC_BA98_7654_3210);
    cfg_rd("R2 flip readback", 2'd1, 64'h0000_0000_0F0F_0F0F);
    cfg_rd("R2 ctrl readback", 2'd2, 64'h0000_0000_0000_001F);
    cfg_wr(2'd2, 64'd0);
  endtask

  task automatic t_oneshot;
    cfg_wr(2'd0, mk_match(5'h1F, 0, 0, 0, 0, 0, 1'b0));
    cfg_wr(2'd1, 64'(M0));
    cfg_wr(2'd2, 64'd14);           // ECC, both halves, one-shot
    set_addr(2'd1, 2'd1, 4'd3, 16'h0042, 14'd7);
    xfer("R7 first write flipped", 1'b1, 1'b0, E0, E0 ^ M0, 1'b0, 1'b1);
    @(posedge clk); #1;
    check("R12 pulse one cycle", 64'(inj_pulse), 64'd0);
    check("R13 page passthrough", 64'(out_page), 64'h0042);
    check("R13 write passthrough", 64'(out_write), 64'd1);
    xfer("R10 second write clean", 1'b1, 1'b1, E0, E0, 1'b0, 1'b0);
    cfg_rd("R12 fired sticky", 2'd3, 64'd1);
    cfg_wr(2'd0, mk_match(5'h1F, 0, 0, 0, 0, 0, 1'b0));
    xfer("R10 re-armed write", 1'b1, 1'b1, E0, E0 ^ M0, 1'b0, 1'b1);
    cfg_wr(2'd2, 64'd14);
    cfg_rd("R12 fired cleared by ctrl", 2'd3, 64'd0);
  endtask

  task automatic t_fields;
    cfg_wr(2'd0, mk_match(5'h00, 2'd1, 2'd2, 4'd5, 16'h1234, 14'h0ABC, 1'b0));
    cfg_wr(2'd2, 64'd15);           // repeat, ECC, both halves
    set_addr(2'd1, 2'd2, 4'd5, 16'h1234, 14'h0ABC);
    xfer("R3 exact match", 1'b1, 1'b0, E0, E0 ^ M0, 1'b0, 1'b1);
    set_addr(2'd1, 2'd2, 4'd5, 16'h1235, 14'h0ABC);
    xfer("R3 page miss", 1'b1, 1'b0, E0, E0, 1'b0, 1'b0);
    set_addr(2'd1, 2'd2, 4'd5, 16'h1234, 14'h0ABD);
    xfer("R3 column miss", 1'b1, 1'b0, E0, E0, 1'b0, 1'b0);
    set_addr(2'd1, 2'd2, 4'd4, 16'h1234, 14'h0ABC);
    xfer("R3 bank miss", 1'b1, 1'b0, E0, E0, 1'b0, 1'b0);
    set_addr(2'd1, 2'd3, 4'd5, 16'h1234, 14'h0ABC);
    xfer("R3 rank miss", 1'b1, 1'b0, E0, E0, 1'b0, 1'b0);
    set_addr(2'd0, 2'd2, 4'd5, 16'h1234, 14'h0ABC);
    xfer("R3 dimm miss", 1'b1, 1'b0, E0, E0, 1'b0, 1'b0);
    cfg_wr(2'd0, mk_match(5'b00010, 2'd1, 2'd2, 4'd5, 16'h1234, 14'h0ABC,
                          1'b0));
    set_addr(2'd1, 2'd2, 4'd5, 16'hBEEF, 14'h0ABC);
    xfer("R3 page ignored", 1'b1, 1'b0, E0, E0 ^ M0, 1'b0, 1'b1);
  endtask

  task automatic t_layout;
    many_dimms = 1'b1;
    cfg_wr(2'd0, mk_match(5'b00111, 2'd3, 2'd1, 0, 0, 0, 1'b1));
    set_addr(2'd3, 2'd1, 4'd0, 16'd0, 14'd0);
    xfer("R4 many dimm3 rank1 hit", 1'b1, 1'b0, E0, E0 ^ M0, 1'b0, 1'b1);
    set_addr(2'd1, 2'd1, 4'd0, 16'd0, 14'd0);
    xfer("R4 many dimm1 miss", 1'b1, 1'b0, E0, E0, 1'b0, 1'b0);
    many_dimms = 1'b0;              // same word: dimm=1 (bit 36), rank=3
    set_addr(2'd1, 2'd3, 4'd0, 16'd0, 14'd0);
    xfer("R4 few dimm1 rank3 hit", 1'b1, 1'b0, E0, E0 ^ M0, 1'b0, 1'b1);
    set_addr(2'd3, 2'd1, 4'd0, 16'd0, 14'd0);
    xfer("R4 few dimm3 rank1 miss", 1'b1, 1'b0, E0, E0, 1'b0, 1'b0);
  endtask

  task automatic t_read_half;
    cfg_wr(2'd0, mk_match(5'h1F, 0, 0, 0, 0, 0, 1'b0));
    cfg_wr(2'd2, 64'd31);           // repeat, both halves, ECC and parity
    xfer("R5 read untouched", 1'b0, 1'b0, E0, E0, 1'b0, 1'b0);
    check("R5 read flag out", 64'(out_write), 64'd0);
    cfg_wr(2'd2, 64'd11);           // repeat, lower, ECC
    xfer("R6 lower selected", 1'b1, 1'b0, E0, E0 ^ M0, 1'b0, 1'b1);
    xfer("R6 upper not selected", 1'b1, 1'b1, E0, E0, 1'b0, 1'b0);
    cfg_wr(2'd2, 64'd13);           // repeat, upper, ECC
    xfer("R6 upper selected", 1'b1, 1'b1, E0, E0 ^ M0, 1'b0, 1'b1);
    xfer("R6 lower not selected", 1'b1, 1'b0, E0, E0, 1'b0, 1'b0);
    cfg_wr(2'd2, 64'd9);            // repeat, no half, ECC
    xfer("R6 no half", 1'b1, 1'b0, E0, E0, 1'b0, 1'b0);
  endtask

  task automatic t_parity_mask;
    cfg_wr(2'd2, 64'd23);           // repeat, both halves, parity only
    xfer("R8 parity only", 1'b1, 1'b0, E0, E0, 1'b1, 1'b1);
    cfg_wr(2'd2, 64'd31);
    xfer("R8 parity and ECC", 1'b1, 1'b1, E0, E0 ^ M0, 1'b1, 1'b1);
    cfg_wr(2'd1, 64'd0);
    xfer("R9 zero mask no inject", 1'b1, 1'b0, E0, E0, 1'b0, 1'b0);
    cfg_wr(2'd1, 64'(M0));
  endtask

  task automatic t_repeat;
    cfg_wr(2'd2, 64'd15);
    for (int k = 0; k < 3; k++)
      xfer("R11 repeat write", 1'b1, k[0], E0 + k, (E0 + k) ^ M0, 1'b0, 1'b1);
    cfg_wr(2'd2, 64'd0);
    xfer("R11 cleared ctrl", 1'b1, 1'b0, E0, E0, 1'b0, 1'b0);
  endtask

  initial begin
    #(PER * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; many_dimms = 1'b0; cfg_wen = 1'b0; cfg_addr = 2'd0;
    cfg_wdata = '0; req_valid = 1'b0; req_write = 1'b0; req_half = 1'b0;
    req_ecc = '0;
    set_addr(2'd0, 2'd0, 4'd0, 16'd0, 14'd0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_regs;
    t_oneshot;
    t_fields;
    t_layout;
    t_read_half;
    t_parity_mask;
    t_repeat;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule